// File: doc/BRIEF.md
# Phase-Programmable Sample Pulse Generator

This block places a SAMPLE timing pulse, and in correlated double sampling (CDS) operation a CLAMP pulse as well, at chosen positions inside every period of an incoming pixel clock. It runs on a fast clock at 64 times the pixel rate. A 6-bit edge counter is kept in phase with the pixel clock, so each pixel period splits into 64 edge slots. For each pulse, a programmable start slot and end slot decide where it rises and falls. A pulse whose start lies after its end wraps across the period boundary. This lets the pulse follow a sensor waveform that arrives late relative to the pixel clock.

A byte-wide register write port sets the edge positions, the operating mode and a monitor field. When the monitor field is set, both pulses are copied onto two test pins so they can be viewed next to the sensor signal. New settings are first held in a staging copy and move into use only at the next edge-0 boundary. A period is therefore never cut into a partial pulse.

Top module: `phase_pulse_gen`

## Requirements
- R1: A synchronous reset clears every register and the edge counter to 0 and selects CDS mode. All four outputs are low while reset is applied and in the first cycle after it.
- R2: A rising edge of `pix_clk` is sampled by the fast clock through two synchronizer flops. If `pix_clk` is high at fast edge E0, the edge counter is 0 after fast edge E0+2, and in every other cycle it counts up modulo 64. The outputs are registered once more, so the outputs seen after edge E0+3+k belong to edge slot k.
- R3: When start < end, SAMPLE is high for the slots k with start <= k < end.
- R4: When start > end, SAMPLE is high for k >= start or k < end, so the pulse runs across the period boundary.
- R5: When start equals end, the pulse stays low for the whole period.
- R6: The register addresses are as follows. Clamp start is 0x20, clamp end 0x21, sample start 0x22 and sample end 0x23. The mode register at 0x08 uses bit 0, where 1 selects sample-and-hold and 0 selects CDS. The monitor register at 0x09 uses field bits [4:3]. An edge register takes the low 6 bits of the write data and ignores the upper bits.
- R7: In CDS mode, CLAMP is produced from the clamp start/end registers with the same rules as R3 to R5.
- R8: In sample-and-hold mode, CLAMP stays low. Changing the clamp registers has no effect on any output.
- R9: With monitor field 2'b10, `mon_pin1` follows SAMPLE and `mon_pin2` follows CLAMP. With any other monitor value, both pins are low.
- R10: A write becomes active at the next edge-0 boundary. The rest of the current period keeps the old settings. A write that lands on the same fast edge as the boundary load (the edge that ends slot 63) waits one more full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 64 times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| pix_clk | input | 1 | Pixel clock, sampled in the fast domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sample_pulse | output | 1 | Registered SAMPLE pulse |
| clamp_pulse | output | 1 | Registered CLAMP pulse |
| mon_pin1 | output | 1 | Test pin 1, carries SAMPLE when monitoring |
| mon_pin2 | output | 1 | Test pin 2, carries CLAMP when monitoring |

## Verification
Two events can fall on the same fast edge: a register write landing in the staging copy, and the edge-0 boundary load that copies staging into the active set. The bench provokes this by timing a write strobe so that it is captured on exactly the edge that closes slot 63. It then sweeps the next period against the old settings and the period after that against the new ones. A second case places a write in the middle of a period and confirms that the remaining slots still follow the old window before the change shows up from slot 0.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
   typedef enum logic [1:0] {
      MON_QUIET0 = 2'b00,
      MON_QUIET1 = 2'b01,
      MON_PULSES = 2'b10,
      MON_QUIET3 = 2'b11
   } ppg_mon_e;

   localparam int PPG_NUM_CH   = 2;
   localparam int PPG_CH_SMP   = 0;
   localparam int PPG_CH_CLP   = 1;
   localparam int PPG_MON_LSB  = 3;
   localparam int PPG_MODE_BIT = 0;
endpackage

// File: rtl/ppg_edge_counter.sv
module ppg_edge_counter #(
   parameter int EDGE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_clk,
   output logic [EDGE_W-1:0] cnt_o,
   output logic              rise_o,
   output logic              boundary_o
);
   logic [SYNC_STAGES:0] sync_q;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-1:0], pix_clk};
   end

   assign rise_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   always_ff @(posedge clk) begin
      if (rst)         cnt_o <= '0;
      else if (rise_o) cnt_o <= '0;
      else             cnt_o <= cnt_o + 1'b1;
   end

   assign boundary_o = rise_o | (cnt_o == '1);
endmodule

// File: rtl/ppg_window.sv
module ppg_window #(
   parameter int EDGE_W = 6
) (
   input  logic [EDGE_W-1:0] cnt,
   input  logic [EDGE_W-1:0] lo,
   input  logic [EDGE_W-1:0] hi,
   output logic              hit
);
   always_comb begin
      if (lo < hi)      hit = (cnt >= lo) && (cnt < hi);
      else if (lo > hi) hit = (cnt >= lo) || (cnt < hi);
      else              hit = 1'b0;
   end
endmodule

// File: rtl/ppg_cfg_regs.sv
module ppg_cfg_regs
   import ppg_pkg::*;
#(
   parameter int                EDGE_W         = 6,
   parameter int                ADDR_W         = 8,
   parameter int                DATA_W         = 8,
   parameter logic [ADDR_W-1:0] ADDR_CLP_START = 'h20,
   parameter logic [ADDR_W-1:0] ADDR_CLP_END   = 'h21,
   parameter logic [ADDR_W-1:0] ADDR_SMP_START = 'h22,
   parameter logic [ADDR_W-1:0] ADDR_SMP_END   = 'h23,
   parameter logic [ADDR_W-1:0] ADDR_MODE      = 'h08,
   parameter logic [ADDR_W-1:0] ADDR_MON       = 'h09
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output logic [EDGE_W-1:0] act_smp_start,
   output logic [EDGE_W-1:0] act_smp_end,
   output logic [EDGE_W-1:0] act_clp_start,
   output logic [EDGE_W-1:0] act_clp_end,
   output logic              act_sh,
   output ppg_mon_e          act_mon
);
   logic [EDGE_W-1:0] stg_smp_start, stg_smp_end, stg_clp_start, stg_clp_end;
   logic              stg_sh;
   ppg_mon_e          stg_mon;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg_smp_start <= '0;
         stg_smp_end   <= '0;
         stg_clp_start <= '0;
         stg_clp_end   <= '0;
         stg_sh        <= 1'b0;
         stg_mon       <= MON_QUIET0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_CLP_START: stg_clp_start <= wr_data[EDGE_W-1:0];
            ADDR_CLP_END:   stg_clp_end   <= wr_data[EDGE_W-1:0];
            ADDR_SMP_START: stg_smp_start <= wr_data[EDGE_W-1:0];
            ADDR_SMP_END:   stg_smp_end   <= wr_data[EDGE_W-1:0];
            ADDR_MODE:      stg_sh        <= wr_data[PPG_MODE_BIT];
            ADDR_MON:       stg_mon       <= ppg_mon_e'(wr_data[PPG_MON_LSB+1:PPG_MON_LSB]);
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act_smp_start <= '0;
         act_smp_end   <= '0;
         act_clp_start <= '0;
         act_clp_end   <= '0;
         act_sh        <= 1'b0;
         act_mon       <= MON_QUIET0;
      end else if (load) begin
         act_smp_start <= stg_smp_start;
         act_smp_end   <= stg_smp_end;
         act_clp_start <= stg_clp_start;
         act_clp_end   <= stg_clp_end;
         act_sh        <= stg_sh;
         act_mon       <= stg_mon;
      end
   end
endmodule

// File: rtl/phase_pulse_gen.sv
module phase_pulse_gen
   import ppg_pkg::*;
#(
   parameter int                EDGE_W         = 6,
   parameter int                ADDR_W         = 8,
   parameter int                DATA_W         = 8,
   parameter int                SYNC_STAGES    = 2,
   parameter logic [ADDR_W-1:0] ADDR_CLP_START = 'h20,
   parameter logic [ADDR_W-1:0] ADDR_CLP_END   = 'h21,
   parameter logic [ADDR_W-1:0] ADDR_SMP_START = 'h22,
   parameter logic [ADDR_W-1:0] ADDR_SMP_END   = 'h23,
   parameter logic [ADDR_W-1:0] ADDR_MODE      = 'h08,
   parameter logic [ADDR_W-1:0] ADDR_MON       = 'h09
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sample_pulse,
   output logic              clamp_pulse,
   output logic              mon_pin1,
   output logic              mon_pin2
);
   localparam int SLOTS = 1 << EDGE_W;

   generate
      if (EDGE_W < 1 || EDGE_W > DATA_W)
         $error("EDGE_W must fit in the write data");
      if (DATA_W < PPG_MON_LSB + 2)
         $error("DATA_W too narrow for the monitor field");
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
      if (SLOTS < 2)
         $error("at least two edge slots required");
   endgenerate

   logic [EDGE_W-1:0] edge_cnt;
   logic              pix_rise;
   logic              cfg_load;
   logic [EDGE_W-1:0] act_smp_start, act_smp_end, act_clp_start, act_clp_end;
   logic              act_sh;
   ppg_mon_e          act_mon;

   ppg_edge_counter #(.EDGE_W(EDGE_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
      .clk(clk), .rst(rst), .pix_clk(pix_clk),
      .cnt_o(edge_cnt), .rise_o(pix_rise), .boundary_o(cfg_load)
   );

   ppg_cfg_regs #(
      .EDGE_W(EDGE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ADDR_CLP_START(ADDR_CLP_START), .ADDR_CLP_END(ADDR_CLP_END),
      .ADDR_SMP_START(ADDR_SMP_START), .ADDR_SMP_END(ADDR_SMP_END),
      .ADDR_MODE(ADDR_MODE), .ADDR_MON(ADDR_MON)
   ) u_cfg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load(cfg_load),
      .act_smp_start(act_smp_start), .act_smp_end(act_smp_end),
      .act_clp_start(act_clp_start), .act_clp_end(act_clp_end),
      .act_sh(act_sh), .act_mon(act_mon)
   );

   logic [EDGE_W-1:0]     win_lo [PPG_NUM_CH];
   logic [EDGE_W-1:0]     win_hi [PPG_NUM_CH];
   logic [PPG_NUM_CH-1:0] win_hit;

   assign win_lo[PPG_CH_SMP] = act_smp_start;
   assign win_hi[PPG_CH_SMP] = act_smp_end;
   assign win_lo[PPG_CH_CLP] = act_clp_start;
   assign win_hi[PPG_CH_CLP] = act_clp_end;

   for (genvar ch = 0; ch < PPG_NUM_CH; ch++) begin : g_win
      ppg_window #(.EDGE_W(EDGE_W)) u_win (
         .cnt(edge_cnt), .lo(win_lo[ch]), .hi(win_hi[ch]), .hit(win_hit[ch])
      );
   end

   logic smp_next, clp_next, mon_on;
   assign smp_next = win_hit[PPG_CH_SMP];
   assign clp_next = win_hit[PPG_CH_CLP] & ~act_sh;
   assign mon_on   = (act_mon == MON_PULSES);

   always_ff @(posedge clk) begin
      if (rst) begin
         sample_pulse <= 1'b0;
         clamp_pulse  <= 1'b0;
         mon_pin1     <= 1'b0;
         mon_pin2     <= 1'b0;
      end else begin
         sample_pulse <= smp_next;
         clamp_pulse  <= clp_next;
         mon_pin1     <= mon_on & smp_next;
         mon_pin2     <= mon_on & clp_next;
      end
   end
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
   parameter int EDGE_W = 6
) (
   input logic              clk,
   input logic              rst,
   input logic [EDGE_W-1:0] cnt,
   input logic              rise,
   input logic              boundary,
   input logic [EDGE_W-1:0] act_ss,
   input logic [EDGE_W-1:0] act_se,
   input logic              act_sh,
   input logic              sample_pulse,
   input logic              clamp_pulse,
   input logic              mon_pin1,
   input logic              mon_pin2
);
   // R1: outputs low in the cycle after a reset cycle
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (!sample_pulse && !clamp_pulse && !mon_pin1 && !mon_pin2));

   // R2: realignment to slot 0 on a detected pixel-clock rise
   p_rise_zero_r2: assert property (@(posedge clk) disable iff (rst)
      rise |=> (cnt == '0));

   // R2: otherwise the counter steps by one, modulo the slot count
   p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
      !rise |=> (cnt == EDGE_W'($past(cnt) + 1'b1)));

   // R5: equal start and end gives no pulse
   p_equal_low_r5: assert property (@(posedge clk) disable iff (rst)
      (act_ss == act_se) |=> !sample_pulse);

   // R8: sample-and-hold keeps the clamp output low
   p_sh_clamp_low_r8: assert property (@(posedge clk) disable iff (rst)
      act_sh |=> !clamp_pulse);

   // R9: test pins only ever carry the pulses themselves
   p_pin1_follows_r9: assert property (@(posedge clk) disable iff (rst)
      mon_pin1 |-> sample_pulse);
   p_pin2_follows_r9: assert property (@(posedge clk) disable iff (rst)
      mon_pin2 |-> clamp_pulse);

   // R10: active settings move only at a boundary
   p_stage_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> ($stable(act_ss) && $stable(act_se) && $stable(act_sh)));
endmodule

bind phase_pulse_gen ppg_checker #(.EDGE_W(EDGE_W)) u_chk (
   .clk(clk), .rst(rst), .cnt(edge_cnt), .rise(pix_rise), .boundary(cfg_load),
   .act_ss(act_smp_start), .act_se(act_smp_end), .act_sh(act_sh),
   .sample_pulse(sample_pulse), .clamp_pulse(clamp_pulse),
   .mon_pin1(mon_pin1), .mon_pin2(mon_pin2)
);

// File: tb/tb_phase_pulse_gen.sv
`timescale 1ns/1ps
module tb_phase_pulse_gen;
   localparam logic [7:0] A_CS = 8'h20, A_CE = 8'h21, A_SS = 8'h22, A_SE = 8'h23;
   localparam logic [7:0] A_MODE = 8'h08, A_MON = 8'h09;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pix = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic sample_pulse, clamp_pulse, mon_pin1, mon_pin2;

   always #2.5 clk = ~clk;

   phase_pulse_gen dut (
      .clk(clk), .rst(rst), .pix_clk(pix), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sample_pulse(sample_pulse), .clamp_pulse(clamp_pulse),
      .mon_pin1(mon_pin1), .mon_pin2(mon_pin2)
   );

   int p = 0;
   always @(posedge clk) p <= p + 1;
   always @(negedge clk) pix <= ((p % 64) < 32);

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int m_ss = 0, m_se = 0, m_cs = 0, m_ce = 0, m_sh = 0, m_mon = 0;

   function automatic bit win(int k, int s, int e);
      if (s < e) return (k >= s) && (k < e);
      if (s > e) return (k >= s) || (k < e);
      return 1'b0;
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at p=%0d: actual %b expected %b", req, what, p, act, exp);
      end
   endtask

   task automatic check_now(string req);
      int  k  = (p + 60) % 64;
      bit  es = win(k, m_ss, m_se);
      bit  ec = (m_sh == 0) && win(k, m_cs, m_ce);
      bit  mo = (m_mon == 2);
      chk(req, "sample", sample_pulse, es);
      chk(req, "clamp",  clamp_pulse,  ec);
      chk(req, "pin1",   mon_pin1,     mo & es);
      chk(req, "pin2",   mon_pin2,     mo & ec);
   endtask

   task automatic wait_phase(int ph);
      do @(negedge clk); while ((p % 64) != ph);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_period(string req);
      wait_phase(3);
      repeat (64) begin
         @(negedge clk);
         check_now(req);
      end
   endtask

   task automatic apply(int ss, int se, int cs, int ce, int sh, int mon);
      wait_phase(10);
      wr(A_SS, 8'(ss)); wr(A_SE, 8'(se)); wr(A_CS, 8'(cs)); wr(A_CE, 8'(ce));
      wr(A_MODE, 8'(sh)); wr(A_MON, 8'(mon << 3));
      m_ss = ss; m_se = se; m_cs = cs; m_ce = ce; m_sh = sh; m_mon = mon;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (6) @(negedge clk);
      // R1: outputs low under reset
      chk("R1", "sample in reset", sample_pulse, 1'b0);
      chk("R1", "clamp in reset",  clamp_pulse,  1'b0);
      chk("R1", "pin1 in reset",   mon_pin1,     1'b0);
      chk("R1", "pin2 in reset",   mon_pin2,     1'b0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "sample after reset", sample_pulse, 1'b0);
      chk("R1", "clamp after reset",  clamp_pulse,  1'b0);
      repeat (150) @(negedge clk);

      // R1 R2 R3 R6 R7 R9: mode left at reset value (CDS), upper data bits ignored
      wait_phase(10);
      wr(A_SS, 8'hCA); wr(A_SE, 8'd40); wr(A_CS, 8'd50); wr(A_CE, 8'd60);
      wr(A_MON, 8'b1001_0111);
      m_ss = 10; m_se = 40; m_cs = 50; m_ce = 60; m_sh = 0; m_mon = 2;
      check_period("R1 R2 R3 R6 R7 R9");

      // R4: wrapping windows on both channels
      apply(50, 12, 60, 3, 0, 2);
      check_period("R4 R7");

      // R3 R4 R9: extreme slots, monitor quiet value 1
      apply(0, 63, 63, 0, 0, 1);
      check_period("R3 R4 R9");

      // R5: equal start and end
      apply(20, 20, 7, 7, 0, 2);
      check_period("R5");

      // R8: sample-and-hold, clamp settings changed without effect
      apply(5, 30, 0, 40, 1, 2);
      check_period("R8");
      wait_phase(10);
      wr(A_CS, 8'd40); wr(A_CE, 8'd10);
      m_cs = 40; m_ce = 10;
      check_period("R8");

      // R9: monitor values 0 and 3 keep pins low
      apply(50, 12, 60, 3, 0, 3);
      check_period("R9");
      apply(50, 12, 60, 3, 0, 0);
      check_period("R9");

      // R10: mid-period write keeps the old window to the end of the period
      apply(10, 40, 50, 60, 0, 2);
      check_period("R10");
      wait_phase(30);
      wr(A_SS, 8'd25);
      check_now("R10");
      while ((p % 64) != 3) begin
         @(negedge clk);
         check_now("R10");
      end
      m_ss = 25;
      repeat (64) begin
         @(negedge clk);
         check_now("R10");
      end

      // R10: write captured on the boundary edge waits one more period
      wait_phase(2);
      wr(A_SE, 8'd60);
      repeat (64) begin
         @(negedge clk);
         check_now("R10");
      end
      m_se = 60;
      repeat (64) begin
         @(negedge clk);
         check_now("R10");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule